// File: doc/BRIEF.md
# Partial-Line Direct-Mapped Instruction Cache

This block sits between an instruction fetch unit and a word-wide memory read port. The fetch side offers a 32-bit byte address with a valid/ready handshake. The cache answers with one 32-bit instruction word, as a one-cycle response pulse. The cache is direct mapped: 256 lines of four 32-bit words. A line is filled only from the requested word to the end of the line, so a line can be partly valid. Each line keeps the full fetch address that started its fill. A later fetch hits only if it matches that address above the line offset and is not below it.

Fetches at or above the uncached boundary go straight to memory as a single word read. They never touch the line storage. A flush input clears every tag and data word to all ones. A flush that arrives while a refill is in flight is held until the refill ends, and then it clears the freshly filled line too. Memory reads that find no backing storage return a zero instruction.

Top module: `pfl_icache`

## Requirements
- R1: After reset, `fetch_ready` is 1, `insn_valid` is 0 and `mem_req` is 0. Every tag and data word holds all ones, so the first cacheable fetch to any line is a miss.
- R2: The line index is fetch address bits 11:4, and the word in the line is bits 3:2. Two cacheable addresses that share bits 11:4 but differ above bit 11 evict each other, so each fetch after the other misses.
- R3: A fetch hits when the stored address equals the fetch address in bits 31:4 and the fetch address is not below the stored address. A hit raises `insn_valid` in the cycle after acceptance, with the stored word, and issues no memory read.
- R4: On a cacheable miss, the cache reads words from the requested word up to word 3, in ascending order, with one read outstanding at a time. Each read address has bits 1:0 equal to 0. The stored address becomes the full fetch address. The response carries the data of the first read, and `fetch_ready` stays low until the last read of the refill returns.
- R5: After a fill that started at word k, a fetch to a word below k in the same line is a miss. It refills from the lower word to word 3, and later fetches at or above the lower word hit.
- R6: An address at or above 0xA0000000 causes exactly one memory read, at the address with bits 1:0 cleared, and returns its data. No line is allocated, so repeating the fetch reads memory again.
- R7: A read returned with `mem_rabsent` = 1 yields a zero instruction. If this happens on the first read of a refill, the refill stops and nothing is stored, so a repeat of the fetch misses again.
- R8: A flush seen while idle clears the whole cache in one cycle. During that cycle `fetch_ready` is 0, and every cacheable fetch afterwards misses.
- R9: A flush that arrives during a refill does not cut the refill short. The requested word is still returned. When the refill completes, the whole cache is cleared, including the line just filled.
- R10: A hit returns the stored word even if the memory contents at that address have changed since the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear the whole cache (held off during a refill) |
| fetch_valid | input | 1 | A fetch address is offered |
| fetch_addr | input | 32 | Byte address of the fetch |
| fetch_ready | output | 1 | The cache accepts a fetch this cycle |
| insn_valid | output | 1 | One-cycle pulse: `insn_data` holds the answer |
| insn_data | output | 32 | Instruction word returned for the fetch |
| mem_req | output | 1 | One-cycle read request to memory |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rvalid | input | 1 | Memory read data is present |
| mem_rdata | input | 32 | Memory read data |
| mem_rabsent | input | 1 | No storage behind the read address; data is treated as zero |

## Verification
The two functions that can fall in the same cycle are a flush and a line refill. Flush can be raised while a refill's word reads are still outstanding, and it can also be raised in an idle cycle in which a fetch is offered. The bench pulses flush partway through a four-word refill. It then checks that the requested word is still returned correctly and that the full refill count of reads took place. It also checks that a following fetch to a higher word of the same line goes back to memory instead of hitting. For the idle case, the bench checks that `fetch_ready` drops in the flush cycle, and that a line filled before the flush misses afterwards.

// File: rtl/pfl_icache_pkg.sv
package pfl_icache_pkg;

   // Controller sequencing: lookup, send one read, wait for its data.
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } fill_state_t;

   // Where the outstanding read goes when it returns.
   typedef enum logic {
      SRC_FILL   = 1'b0,
      SRC_BYPASS = 1'b1
   } fill_src_t;

endpackage

// File: rtl/pfl_icache_tags.sv
module pfl_icache_tags #(
   parameter int ADDR_W   = 32,
   parameter int LINES    = 256,
   parameter int IDX_W    = 8,
   parameter int LINE_LSB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_all,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_tag,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit
);

   logic [ADDR_W-1:0] tag_vec [LINES];

   // One stored fill address per line; all ones means empty.
   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [ADDR_W-1:0] tag_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clear_all) begin
            tag_q <= '1;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            tag_q <= wr_tag;
         end
      end
      assign tag_vec[g] = tag_q;
   end

   logic [IDX_W-1:0]  lk_idx;
   logic [ADDR_W-1:0] lk_tag;

   assign lk_idx = lk_addr[LINE_LSB +: IDX_W];
   assign lk_tag = tag_vec[lk_idx];

   // Upper bits equal, and the fetch is not below where the fill began.
   assign lk_hit = (lk_tag[ADDR_W-1:LINE_LSB] == lk_addr[ADDR_W-1:LINE_LSB])
                   && (lk_addr >= lk_tag);

endmodule

// File: rtl/pfl_icache_data.sv
module pfl_icache_data #(
   parameter int DATA_W = 32,
   parameter int LINES  = 256,
   parameter int WORDS  = 4,
   parameter int IDX_W  = 8,
   parameter int OFF_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_all,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [OFF_W-1:0]  wr_word,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [OFF_W-1:0]  rd_word,
   output logic [DATA_W-1:0] rd_data
);

   typedef logic [WORDS-1:0][DATA_W-1:0] line_t;

   line_t line_vec [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_t line_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clear_all) begin
            line_q <= '1;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            line_q[wr_word] <= wr_data;
         end
      end
      assign line_vec[g] = line_q;
   end

   line_t rd_line;

   assign rd_line = line_vec[rd_idx];
   assign rd_data = rd_line[rd_word];

endmodule

// File: rtl/pfl_icache_ctrl.sv
module pfl_icache_ctrl
   import pfl_icache_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int WORDS    = 4,
   parameter int IDX_W    = 8,
   parameter int OFF_W    = 2,
   parameter int LINE_LSB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_ready,
   input  logic              uncached,
   input  logic              lk_hit,
   input  logic [DATA_W-1:0] lk_data,
   output logic              insn_valid,
   output logic [DATA_W-1:0] insn_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rabsent,
   output logic              clear_all,
   output logic              tag_we,
   output logic              data_we,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [OFF_W-1:0]  wr_word,
   output logic [ADDR_W-1:0] wr_tag,
   output logic [DATA_W-1:0] wr_data
);

   localparam int BYTE_W = LINE_LSB - OFF_W;
   localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(WORDS - 1);

   fill_state_t       state_q;
   fill_src_t         src_q;
   logic [ADDR_W-1:0] addr_q;
   logic [OFF_W-1:0]  ptr_q;
   logic              first_q;
   logic              flush_pend_q;
   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_data_q;

   logic              idle;
   logic              flush_any;
   logic              accept;
   logic [DATA_W-1:0] ret_word;
   logic              fill_ret;
   logic              abort;

   assign idle      = (state_q == ST_IDLE);
   assign flush_any = flush | flush_pend_q;

   // A flush owns the idle cycle it lands in; no fetch is taken then.
   assign fetch_ready = idle & ~flush_any;
   assign clear_all   = idle & flush_any;
   assign accept      = fetch_valid & fetch_ready;

   assign mem_req  = (state_q == ST_ISSUE);
   assign mem_addr = {addr_q[ADDR_W-1:LINE_LSB], ptr_q, {BYTE_W{1'b0}}};

   assign ret_word = mem_rabsent ? '0 : mem_rdata;
   assign fill_ret = (state_q == ST_WAIT) && mem_rvalid && (src_q == SRC_FILL);
   assign abort    = fill_ret && first_q && mem_rabsent;

   assign tag_we  = fill_ret && first_q && !mem_rabsent;
   assign data_we = fill_ret && !abort;
   assign wr_idx  = addr_q[LINE_LSB +: IDX_W];
   assign wr_word = ptr_q;
   assign wr_tag  = addr_q;
   assign wr_data = ret_word;

   assign insn_valid = rsp_valid_q;
   assign insn_data  = rsp_data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         src_q        <= SRC_FILL;
         addr_q       <= '0;
         ptr_q        <= '0;
         first_q      <= 1'b0;
         flush_pend_q <= 1'b0;
         rsp_valid_q  <= 1'b0;
         rsp_data_q   <= '0;
      end else begin
         rsp_valid_q <= 1'b0;

         // Flush during a refill waits; the idle cycle after it clears.
         if (idle) begin
            flush_pend_q <= 1'b0;
         end else if (flush) begin
            flush_pend_q <= 1'b1;
         end

         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (!uncached && lk_hit) begin
                     rsp_valid_q <= 1'b1;
                     rsp_data_q  <= lk_data;
                  end else begin
                     src_q   <= uncached ? SRC_BYPASS : SRC_FILL;
                     addr_q  <= fetch_addr;
                     ptr_q   <= fetch_addr[BYTE_W +: OFF_W];
                     first_q <= 1'b1;
                     state_q <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rvalid) begin
                  first_q <= 1'b0;
                  if (first_q) begin
                     rsp_valid_q <= 1'b1;
                     rsp_data_q  <= ret_word;
                  end
                  if ((src_q == SRC_BYPASS) || abort || (ptr_q == LAST_WORD)) begin
                     state_q <= ST_IDLE;
                  end else begin
                     ptr_q   <= ptr_q + 1'b1;
                     state_q <= ST_ISSUE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pfl_icache.sv
module pfl_icache #(
   parameter int          ADDR_W        = 32,
   parameter int          DATA_W        = 32,
   parameter int          LINES         = 256,
   parameter int          WORDS         = 4,
   parameter bit          BYPASS_EN     = 1'b1,
   parameter logic [31:0] UNCACHED_BASE = 32'hA000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_ready,
   output logic              insn_valid,
   output logic [DATA_W-1:0] insn_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rabsent
);

   localparam int IDX_W    = $clog2(LINES);
   localparam int OFF_W    = $clog2(WORDS);
   localparam int BYTE_W   = $clog2(DATA_W / 8);
   localparam int LINE_LSB = OFF_W + BYTE_W;

   initial begin
      assert ((1 << IDX_W) == LINES) else $error("LINES must be a power of two");
      assert ((1 << OFF_W) == WORDS && WORDS > 1) else $error("WORDS must be a power of two above one");
      assert (DATA_W % 8 == 0 && (1 << BYTE_W) * 8 == DATA_W) else $error("DATA_W must be a power-of-two byte count");
      assert (LINE_LSB + IDX_W < ADDR_W) else $error("index and offset exceed the address");
   end

   logic              uncached;
   logic              lookup_hit;
   logic [DATA_W-1:0] lookup_data;
   logic              clear_all;
   logic              tag_we;
   logic              data_we;
   logic [IDX_W-1:0]  wr_idx;
   logic [OFF_W-1:0]  wr_word;
   logic [ADDR_W-1:0] wr_tag;
   logic [DATA_W-1:0] wr_data;

   if (BYPASS_EN) begin : g_bypass
      assign uncached = (fetch_addr >= ADDR_W'(UNCACHED_BASE));
   end else begin : g_all_cached
      assign uncached = 1'b0;
   end

   pfl_icache_tags #(
      .ADDR_W(ADDR_W), .LINES(LINES), .IDX_W(IDX_W), .LINE_LSB(LINE_LSB)
   ) u_tags (
      .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
      .wr_en(tag_we), .wr_idx(wr_idx), .wr_tag(wr_tag),
      .lk_addr(fetch_addr), .lk_hit(lookup_hit)
   );

   pfl_icache_data #(
      .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS), .IDX_W(IDX_W), .OFF_W(OFF_W)
   ) u_data (
      .clk(clk), .rst_n(rst_n), .clear_all(clear_all),
      .wr_en(data_we), .wr_idx(wr_idx), .wr_word(wr_word), .wr_data(wr_data),
      .rd_idx(fetch_addr[LINE_LSB +: IDX_W]), .rd_word(fetch_addr[BYTE_W +: OFF_W]),
      .rd_data(lookup_data)
   );

   pfl_icache_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS),
      .IDX_W(IDX_W), .OFF_W(OFF_W), .LINE_LSB(LINE_LSB)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
      .uncached(uncached), .lk_hit(lookup_hit), .lk_data(lookup_data),
      .insn_valid(insn_valid), .insn_data(insn_data),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rabsent(mem_rabsent),
      .clear_all(clear_all), .tag_we(tag_we), .data_we(data_we),
      .wr_idx(wr_idx), .wr_word(wr_word), .wr_tag(wr_tag), .wr_data(wr_data)
   );

endmodule

// File: rtl/pfl_icache_chk.sv
module pfl_icache_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_valid,
   input logic              fetch_ready,
   input logic              insn_valid,
   input logic [DATA_W-1:0] insn_data,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rvalid,
   input logic              mem_rabsent,
   input logic              uncached,
   input logic              lookup_hit,
   input logic              clear_all
);

   // R4: nothing is accepted while a refill read is being sent.
   p_refill_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !fetch_ready);

   // R4: one read outstanding, so a request never repeats back to back.
   p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R3: an accepted hit answers next cycle and stays off the memory port.
   p_hit_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_ready && !uncached && lookup_hit) |=> (insn_valid && !mem_req));

   // R6: an accepted uncached fetch sends one aligned read next cycle.
   p_bypass_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && fetch_ready && uncached) |=> (mem_req && (mem_addr[1:0] == 2'b00)));

   // R7: an answer built from an absent read is zero.
   p_absent_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && $past(mem_rvalid && mem_rabsent)) |-> (insn_data == '0));

   // R8: right after a clear no cacheable address can hit.
   p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear_all |=> !(lookup_hit && !uncached));

endmodule

bind pfl_icache pfl_icache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
   .insn_valid(insn_valid), .insn_data(insn_data),
   .mem_req(mem_req), .mem_addr(mem_addr),
   .mem_rvalid(mem_rvalid), .mem_rabsent(mem_rabsent),
   .uncached(uncached), .lookup_hit(lookup_hit), .clear_all(clear_all)
);

// File: tb/pfl_icache_tb.sv
module pfl_icache_tb;

   localparam int CLK_PERIOD = 10;
   localparam int MEM_LAT    = 3;
   localparam int WDOG       = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        fetch_ready;
   logic        insn_valid;
   logic [31:0] insn_data;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_rabsent = 1'b0;

   int total = 0;
   int bad = 0;
   int req_count = 0;
   int ver = 0;
   int cnt = 0;
   int log_n = 0;
   logic [31:0] pend_addr = '0;
   logic [31:0] req_log [8];

   always #(CLK_PERIOD / 2) clk = ~clk;

   pfl_icache u_dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
      .insn_valid(insn_valid), .insn_data(insn_data),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rabsent(mem_rabsent)
   );

   // Backing store contents: derived from the word address and a version.
   function automatic logic [31:0] mem_val(logic [31:0] a, int v);
      return {a[31:2], 2'b00} ^ 32'h3C3C_0F0F ^ (32'(v) * 32'h0011_0000);
   endfunction

   function automatic bit is_absent(logic [31:0] a);
      return (a[31:24] == 8'h1F) || (a[31:24] == 8'hBF);
   endfunction

   // Fixed-latency memory, everything moves on the falling edge.
   always @(negedge clk) begin
      if (mem_rvalid) begin
         mem_rvalid  = 1'b0;
         mem_rabsent = 1'b0;
      end
      if (cnt != 0) begin
         cnt = cnt - 1;
         if (cnt == 0) begin
            mem_rvalid  = 1'b1;
            mem_rabsent = is_absent(pend_addr);
            mem_rdata   = is_absent(pend_addr) ? 32'hDEAD_BEEF : mem_val(pend_addr, ver);
         end
      end
      if (mem_req) begin
         pend_addr = mem_addr;
         cnt = MEM_LAT;
         if (log_n < 8) req_log[log_n] = mem_addr;
         log_n = log_n + 1;
         req_count = req_count + 1;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Offer one fetch, return the answer, memory reads used, and answer latency.
   task automatic fetch(input logic [31:0] a, output logic [31:0] d, output int reqs, output int lat);
      int r0;
      @(negedge clk);
      r0 = req_count;
      log_n = 0;
      fetch_valid = 1'b1;
      fetch_addr  = a;
      while (!fetch_ready) @(negedge clk);
      @(negedge clk);
      fetch_valid = 1'b0;
      lat = 1;
      while (!insn_valid) begin
         @(negedge clk);
         lat++;
      end
      d = insn_data;
      while (!fetch_ready) @(negedge clk);
      reqs = req_count - r0;
   endtask

   // addr | expected reads | expect hit | requirement number
   localparam int NV = 10;
   localparam logic [40:0] VEC [NV] = '{
      {32'h0000_1008, 4'd2, 1'b0, 4'd4},  // R4 miss at word 2 reads words 2,3
      {32'h0000_100C, 4'd0, 1'b1, 4'd3},  // R3 hit above fill start
      {32'h0000_1000, 4'd4, 1'b0, 4'd5},  // R5 lower word misses, refills 0..3
      {32'h0000_1004, 4'd0, 1'b1, 4'd5},  // R5 now hits
      {32'h0000_2004, 4'd3, 1'b0, 4'd2},  // R2 same index, other tag
      {32'h0000_1004, 4'd3, 1'b0, 4'd2},  // R2 evicted, misses again
      {32'h0000_1FF0, 4'd4, 1'b0, 4'd2},  // R2 last index, word 0
      {32'h0000_1FFC, 4'd0, 1'b1, 4'd3},  // R3 hit at last word
      {32'h A000_1000 , 4'd1, 1'b0, 4'd6},  // R6 bypass
      {32'hA000_1000, 4'd1, 1'b0, 4'd6}   // R6 bypass never allocates
   };

   initial begin : watchdog
      repeat (WDOG) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", WDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      int reqs;
      int lat;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(fetch_ready == 1'b1, "R1 ready after reset", 32'(fetch_ready), 32'd1);
      chk(insn_valid == 1'b0, "R1 no answer after reset", 32'(insn_valid), 32'd0);
      chk(mem_req == 1'b0, "R1 no read after reset", 32'(mem_req), 32'd0);

      for (int i = 0; i < NV; i++) begin
         logic [31:0] a;
         int er;
         bit eh;
         int rid;
         string tag;
         a   = VEC[i][40:9];
         er  = int'(VEC[i][8:5]);
         eh  = VEC[i][4];
         rid = int'(VEC[i][3:0]);
         fetch(a, d, reqs, lat);
         tag = $sformatf("R%0d vec%0d", rid, i);
         chk(d == mem_val(a, 0), {tag, " data"}, d, mem_val(a, 0));
         chk(reqs == er, {tag, " reads"}, 32'(reqs), 32'(er));
         if (eh) chk(lat == 1, {tag, " hit latency"}, 32'(lat), 32'd1);
         else    chk(lat > 1, {tag, " miss latency"}, 32'(lat), 32'd2);
         if (i == 0) begin
            // R4 ascending, aligned read order
            chk(req_log[0] == 32'h0000_1008, "R4 first read", req_log[0], 32'h0000_1008);
            chk(req_log[1] == 32'h0000_100C, "R4 second read", req_log[1], 32'h0000_100C);
         end
      end

      // R1: the very first fill touched only lines 0 and 255; another line is empty.
      fetch(32'h0000_0130, d, reqs, lat);
      chk(reqs == 4, "R1 untouched line misses", 32'(reqs), 32'd4);

      // R10: memory changes, cached words stay, bypass sees the new value.
      ver = 1;
      fetch(32'h0000_1FF4, d, reqs, lat);
      chk(d == mem_val(32'h0000_1FF4, 0), "R10 stale hit data", d, mem_val(32'h0000_1FF4, 0));
      chk(reqs == 0, "R10 stale hit reads", 32'(reqs), 32'd0);
      fetch(32'hA000_1000, d, reqs, lat);
      chk(d == mem_val(32'hA000_1000, 1), "R10 bypass sees new data", d, mem_val(32'hA000_1000, 1));

      // R7: absent storage answers zero and a failed refill allocates nothing.
      fetch(32'h1F00_0010, d, reqs, lat);
      chk(d == 32'h0, "R7 absent cached data", d, 32'h0);
      chk(reqs == 1, "R7 refill stops at first read", 32'(reqs), 32'd1);
      fetch(32'h1F00_0010, d, reqs, lat);
      chk(reqs == 1, "R7 no allocation after absent", 32'(reqs), 32'd1);
      fetch(32'hBF00_0004, d, reqs, lat);
      chk(d == 32'h0, "R7 absent bypass data", d, 32'h0);

      // R8: flush while idle.
      fetch(32'h0000_3000, d, reqs, lat);
      fetch(32'h0000_3008, d, reqs, lat);
      chk(reqs == 0, "R8 line present before flush", 32'(reqs), 32'd0);
      @(negedge clk);
      flush = 1'b1;
      fetch_valid = 1'b1;
      fetch_addr = 32'h0000_3004;
      #1;
      chk(fetch_ready == 1'b0, "R8 ready low in flush cycle", 32'(fetch_ready), 32'd0);
      @(negedge clk);
      flush = 1'b0;
      fetch_valid = 1'b0;
      fetch(32'h0000_3008, d, reqs, lat);
      chk(reqs == 2, "R8 miss after flush", 32'(reqs), 32'd2);
      chk(d == mem_val(32'h0000_3008, 1), "R8 data after flush", d, mem_val(32'h0000_3008, 1));

      // R9: flush arriving in the middle of a refill.
      fork
         fetch(32'h0000_4000, d, reqs, lat);
         begin
            repeat (5) @(negedge clk);
            flush = 1'b1;
            @(negedge clk);
            flush = 1'b0;
         end
      join
      chk(d == mem_val(32'h0000_4000, 1), "R9 answer during deferred flush", d, mem_val(32'h0000_4000, 1));
      chk(reqs == 4, "R9 refill not cut short", 32'(reqs), 32'd4);
      fetch(32'h0000_4004, d, reqs, lat);
      chk(reqs == 3, "R9 filled line cleared afterwards", 32'(reqs), 32'd3);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule